// File: doc/BRIEF.md
# Write-Back Cache Maintenance Controller

This block keeps the tag, valid, dirty and line-data state of a small direct-mapped write-back data cache. It carries out explicit maintenance commands on that state. Commands come from a local command port or, as purge requests, from an external bus agent. All addresses are physical and are compared directly against the stored tags.

Each accepted command looks up the line selected by its address and updates that line's state. When dirty data has to leave the cache, the block offers the whole line on a write-back port with a valid/ready handshake. The memory side acknowledges each finished transfer on a separate retire input. A synchronization command completes only once every transfer that has been handed over has also been retired. Line refill and normal load/store servicing are handled elsewhere.

Every accepted request ends with exactly one completion pulse. The pulse reports which port issued the request and whether the lookup hit.

Top module: `wbc_maint_ctrl`

## Requirements
- R1: After reset every line is invalid and clean, both request ports are ready, and the write-back valid, completion and instruction-invalidate outputs are low.
- R2: Operation code 0 (discard) on a hit clears the line's valid and dirty bits without any write-back, even when the line is dirty; a later lookup of that address misses.
- R3: Operation code 1 (purge) on a hit writes the line back first if it is dirty, then invalidates it; on a clean hit it invalidates without a write-back.
- R4: Operation code 2 (clean) on a dirty hit writes the line back and leaves it valid but clean, so a repeated clean reports a hit and produces no write-back.
- R5: Operation code 3 (allocate) installs the request's tag and line data as valid and dirty without reading memory. If the old line at that index is valid, dirty and carries a different tag, that old line is written back first, with its own address and data.
- R6: Operation code 4 (instruction-side invalidate) pulses the instruction-invalidate output with the request address in the completion cycle, and leaves the data cache state unchanged.
- R7: A lookup that misses, and operation codes 6 and 7, produce no write-back and report no hit.
- R8: A bus purge request behaves as operation code 1 on its physical address; any byte offset within the line matches.
- R9: Operation code 5 (sync) completes only when the count of handed-over but unretired write-backs is zero. This holds whatever the cache enable.
- R10: While the cache enable is low, every request other than sync completes as a no-op: no state change, no write-back, no instruction-invalidate pulse, and no hit.
- R11: When both ports request in the same idle cycle, the bus request is accepted and the local port is held not ready.
- R12: A write-back holds its valid, line-aligned address and data stable until accepted. Valid stays low while MAX_OUT write-backs are unretired.
- R13: A request that needs no write-back and no sync wait completes in the second cycle after acceptance. The completion carries the issuing port: 0 for local, 1 for bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_en_i | input | 1 | Data cache enable |
| lc_valid_i | input | 1 | Local command valid |
| lc_ready_o | output | 1 | Local command accepted this cycle when valid |
| lc_op_i | input | 3 | Local operation code |
| lc_addr_i | input | ADDR_W | Local command physical address |
| lc_data_i | input | LINE_BYTES*8 | Line data for allocate |
| bp_valid_i | input | 1 | Bus purge request valid |
| bp_ready_o | output | 1 | Bus purge accepted this cycle when valid |
| bp_addr_i | input | ADDR_W | Bus purge physical address |
| wb_valid_o | output | 1 | Write-back line offered |
| wb_ready_i | input | 1 | Memory accepts the write-back |
| wb_addr_o | output | ADDR_W | Line-aligned write-back address |
| wb_data_o | output | LINE_BYTES*8 | Write-back line data |
| wb_done_i | input | 1 | One previously accepted write-back has finished |
| done_valid_o | output | 1 | Request completion pulse |
| done_src_o | output | 1 | Issuing port of the completed request (1 = bus) |
| done_hit_o | output | 1 | Completed lookup hit |
| ic_inval_o | output | 1 | Instruction-side invalidate strobe |
| ic_addr_o | output | ADDR_W | Instruction-side invalidate address |

## Verification
The bench builds the block with LINES = 8 and MAX_OUT = 2, keeping the 16-byte line and 32-bit address. Eight lines let random addresses drawn from three tags collide often, so dirty-victim evictions, hits on clean lines and misses on reused indices all occur many times in a short run. A limit of two unretired write-backs means the back-pressure stall on a full tracker and the sync wait on outstanding transfers are reached repeatedly, not just once in a directed case.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [2:0] {
        OP_INV   = 3'd0,
        OP_PURGE = 3'd1,
        OP_WBACK = 3'd2,
        OP_ALLOC = 3'd3,
        OP_ICINV = 3'd4,
        OP_SYNC  = 3'd5,
        OP_NOP6  = 3'd6,
        OP_NOP7  = 3'd7
    } maint_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WB   = 2'd2,
        ST_SYNC = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
    parameter int LINES  = 64,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_valid_o,
    output logic              rd_dirty_o,
    output logic [TAG_W-1:0]  rd_tag_o,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic              wr_all_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic              wr_valid_i,
    input  logic              wr_dirty_i,
    input  logic [TAG_W-1:0]  wr_tag_i,
    input  logic [DATA_W-1:0] wr_data_i
);

    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel;
        assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else if (sel) begin
                valid_q[g] <= wr_valid_i;
                dirty_q[g] <= wr_dirty_i;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && wr_all_i) begin
                tag_q[g]  <= wr_tag_i;
                data_q[g] <= wr_data_i;
            end
        end
    end

    assign rd_valid_o = valid_q[rd_idx_i];
    assign rd_dirty_o = dirty_q[rd_idx_i];
    assign rd_tag_o   = tag_q[rd_idx_i];
    assign rd_data_o  = data_q[rd_idx_i];

    // R2: a line that is not valid never holds dirty data
    p_dirty_implies_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0);

endmodule

// File: rtl/wbc_wb_tracker.sv
module wbc_wb_tracker #(
    parameter int MAX_OUT = 4,
    parameter int CNT_W   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic retire_i,
    output logic full_o,
    output logic empty_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (issue_i && !retire_i) begin
            cnt_d = cnt_q + 1'b1;
        end else if (!issue_i && retire_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign full_o  = (cnt_q == CNT_W'(MAX_OUT));
    assign empty_o = (cnt_q == '0);

    // R12: the count of unretired write-backs never passes its limit
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_OUT));

    // R12: no new write-back is handed over while the limit is reached
    p_full_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !issue_i);

endmodule

// File: rtl/wbc_req_arb.sv
module wbc_req_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    input  logic bp_valid_i,
    input  logic lc_valid_i,
    output logic bp_ready_o,
    output logic lc_ready_o,
    output logic gnt_bus_o,
    output logic gnt_loc_o
);

    assign bp_ready_o = idle_i;
    assign lc_ready_o = idle_i && !bp_valid_i;
    assign gnt_bus_o  = bp_ready_o && bp_valid_i;
    assign gnt_loc_o  = lc_ready_o && lc_valid_i;

    // R11: at most one request is taken per cycle
    p_single_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_bus_o, gnt_loc_o}));

endmodule

// File: rtl/wbc_maint_ctrl.sv
module wbc_maint_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int LINES      = 64,
    parameter int MAX_OUT    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cache_en_i,
    input  logic                      lc_valid_i,
    output logic                      lc_ready_o,
    input  logic [2:0]                lc_op_i,
    input  logic [ADDR_W-1:0]         lc_addr_i,
    input  logic [LINE_BYTES*8-1:0]   lc_data_i,
    input  logic                      bp_valid_i,
    output logic                      bp_ready_o,
    input  logic [ADDR_W-1:0]         bp_addr_i,
    output logic                      wb_valid_o,
    input  logic                      wb_ready_i,
    output logic [ADDR_W-1:0]         wb_addr_o,
    output logic [LINE_BYTES*8-1:0]   wb_data_o,
    input  logic                      wb_done_i,
    output logic                      done_valid_o,
    output logic                      done_src_o,
    output logic                      done_hit_o,
    output logic                      ic_inval_o,
    output logic [ADDR_W-1:0]         ic_addr_o
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int DATA_W = LINE_BYTES * 8;
    localparam int CNT_W  = $clog2(MAX_OUT + 1);

    typedef struct packed {
        ctl_state_e        state;
        maint_op_e         op;
        logic              src;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] ldata;
        logic              wb_valid;
        logic [ADDR_W-1:0] wb_addr;
        logic [DATA_W-1:0] wb_data;
        logic              upd_v;
        logic              upd_d;
        logic              upd_all;
        logic              pend_hit;
        logic              done;
        logic              done_src;
        logic              done_hit;
        logic              ic;
    } ctl_t;

    ctl_t q, n;

    logic              idle, gnt_bus, gnt_loc;
    logic              trk_full, trk_empty, wb_fire;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              hit;
    logic              wr_en, wr_all, wr_valid, wr_dirty;
    logic              fin, fin_hit;

    assign idle    = (q.state == ST_IDLE);
    assign cur_idx = q.addr[OFF_W +: IDX_W];
    assign cur_tag = q.addr[ADDR_W-1 -: TAG_W];
    assign hit     = cache_en_i && rd_valid && (rd_tag == cur_tag);
    assign wb_valid_o = q.wb_valid && !trk_full;
    assign wb_fire    = wb_valid_o && wb_ready_i;

    wbc_req_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_i     (idle),
        .bp_valid_i (bp_valid_i),
        .lc_valid_i (lc_valid_i),
        .bp_ready_o (bp_ready_o),
        .lc_ready_o (lc_ready_o),
        .gnt_bus_o  (gnt_bus),
        .gnt_loc_o  (gnt_loc)
    );

    wbc_line_store #(
        .LINES  (LINES),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_i   (cur_idx),
        .rd_valid_o (rd_valid),
        .rd_dirty_o (rd_dirty),
        .rd_tag_o   (rd_tag),
        .rd_data_o  (rd_data),
        .wr_en_i    (wr_en),
        .wr_all_i   (wr_all),
        .wr_idx_i   (cur_idx),
        .wr_valid_i (wr_valid),
        .wr_dirty_i (wr_dirty),
        .wr_tag_i   (cur_tag),
        .wr_data_i  (q.ldata)
    );

    wbc_wb_tracker #(
        .MAX_OUT (MAX_OUT),
        .CNT_W   (CNT_W)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (wb_fire),
        .retire_i (wb_done_i),
        .full_o   (trk_full),
        .empty_o  (trk_empty)
    );

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        n.ic     = 1'b0;
        wr_en    = 1'b0;
        wr_all   = 1'b0;
        wr_valid = 1'b0;
        wr_dirty = 1'b0;
        fin      = 1'b0;
        fin_hit  = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                if (gnt_bus) begin
                    n.state = ST_LOOK;
                    n.op    = OP_PURGE;
                    n.src   = 1'b1;
                    n.addr  = bp_addr_i;
                end else if (gnt_loc) begin
                    n.state = ST_LOOK;
                    n.op    = maint_op_e'(lc_op_i);
                    n.src   = 1'b0;
                    n.addr  = lc_addr_i;
                    n.ldata = lc_data_i;
                end
            end

            ST_LOOK: begin
                n.wb_addr = {rd_tag, cur_idx, {OFF_W{1'b0}}};
                n.wb_data = rd_data;
                n.pend_hit = hit;
                if (q.op == OP_SYNC) begin
                    if (trk_empty) fin = 1'b1;
                    else           n.state = ST_SYNC;
                end else if (!cache_en_i) begin
                    fin = 1'b1;
                end else begin
                    unique case (q.op)
                        OP_INV: begin
                            wr_en   = hit;
                            fin     = 1'b1;
                            fin_hit = hit;
                        end
                        OP_PURGE: begin
                            if (hit && rd_dirty) begin
                                n.state    = ST_WB;
                                n.wb_valid = 1'b1;
                                n.upd_v    = 1'b0;
                                n.upd_d    = 1'b0;
                                n.upd_all  = 1'b0;
                            end else begin
                                wr_en   = hit;
                                fin     = 1'b1;
                                fin_hit = hit;
                            end
                        end
                        OP_WBACK: begin
                            if (hit && rd_dirty) begin
                                n.state    = ST_WB;
                                n.wb_valid = 1'b1;
                                n.upd_v    = 1'b1;
                                n.upd_d    = 1'b0;
                                n.upd_all  = 1'b0;
                            end else begin
                                fin     = 1'b1;
                                fin_hit = hit;
                            end
                        end
                        OP_ALLOC: begin
                            if (rd_valid && rd_dirty && !hit) begin
                                n.state    = ST_WB;
                                n.wb_valid = 1'b1;
                                n.upd_v    = 1'b1;
                                n.upd_d    = 1'b1;
                                n.upd_all  = 1'b1;
                            end else begin
                                wr_en    = 1'b1;
                                wr_all   = 1'b1;
                                wr_valid = 1'b1;
                                wr_dirty = 1'b1;
                                fin      = 1'b1;
                                fin_hit  = hit;
                            end
                        end
                        OP_ICINV: begin
                            n.ic = 1'b1;
                            fin  = 1'b1;
                        end
                        default: begin
                            fin = 1'b1;
                        end
                    endcase
                end
            end

            ST_WB: begin
                if (wb_fire) begin
                    wr_en      = 1'b1;
                    wr_all     = q.upd_all;
                    wr_valid   = q.upd_v;
                    wr_dirty   = q.upd_d;
                    n.wb_valid = 1'b0;
                    fin        = 1'b1;
                    fin_hit    = q.pend_hit;
                end
            end

            ST_SYNC: begin
                if (trk_empty) fin = 1'b1;
            end

            default: n.state = ST_IDLE;
        endcase

        if (fin) begin
            n.state    = ST_IDLE;
            n.done     = 1'b1;
            n.done_src = q.src;
            n.done_hit = fin_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign wb_addr_o    = q.wb_addr;
    assign wb_data_o    = q.wb_data;
    assign done_valid_o = q.done;
    assign done_src_o   = q.done_src;
    assign done_hit_o   = q.done_hit;
    assign ic_inval_o   = q.ic;
    assign ic_addr_o    = q.addr;

    // R12: an offered line stays put until memory takes it
    p_wb_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && !wb_ready_i) |=>
            (wb_valid_o && $stable(wb_addr_o) && $stable(wb_data_o)));

    // R12: write-back addresses are whole-line aligned
    p_wb_aligned_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> (wb_addr_o[OFF_W-1:0] == '0));

    // R7: a missing discard, purge or clean never starts a write-back
    p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_LOOK && !hit &&
         (q.op == OP_INV || q.op == OP_PURGE || q.op == OP_WBACK)) |=> !q.wb_valid);

    // R10: with the cache off a non-sync request finishes at once, quietly
    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_LOOK && !cache_en_i && q.op != OP_SYNC) |=>
            (q.state == ST_IDLE && q.done && !q.ic && !q.wb_valid && !q.done_hit));

    // R9: sync completes only with nothing left unretired
    p_sync_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid_o && q.op == OP_SYNC) |-> trk_empty);

    // R11: a bus request seen while idle is the one taken
    p_bus_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && bp_valid_i) |=> (q.state == ST_LOOK && q.src));

    // R6: the instruction-side strobe only comes with a completion
    p_ic_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ic_inval_o |-> done_valid_o);

endmodule

// File: tb/wbc_maint_ctrl_tb_top.sv
`timescale 1ns/1ps
module wbc_maint_ctrl_tb_top;

    localparam int ADDR_W = 32;
    localparam int LBYTES = 16;
    localparam int B_LINES = 8;
    localparam int B_MAX  = 2;
    localparam int OFF_W  = 4;
    localparam int IDX_W  = 3;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int DW     = LBYTES * 8;

    localparam logic [2:0] C_INV = 3'd0, C_PURGE = 3'd1, C_WBACK = 3'd2,
                           C_ALLOC = 3'd3, C_ICINV = 3'd4, C_SYNC = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cache_en = 1'b1;
    logic lc_valid = 1'b0;
    logic [2:0] lc_op = '0;
    logic [ADDR_W-1:0] lc_addr = '0;
    logic [DW-1:0] lc_data = '0;
    logic bp_valid = 1'b0;
    logic [ADDR_W-1:0] bp_addr = '0;
    logic wb_ready = 1'b0;
    logic wb_done = 1'b0;
    logic lc_ready_o, bp_ready_o, wb_valid_o, done_valid_o, done_src_o, done_hit_o, ic_inval_o;
    logic [ADDR_W-1:0] wb_addr_o, ic_addr_o;
    logic [DW-1:0] wb_data_o;

    always #2.5 clk = ~clk;

    wbc_maint_ctrl #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LBYTES), .LINES(B_LINES), .MAX_OUT(B_MAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cache_en_i(cache_en),
        .lc_valid_i(lc_valid), .lc_ready_o(lc_ready_o), .lc_op_i(lc_op),
        .lc_addr_i(lc_addr), .lc_data_i(lc_data),
        .bp_valid_i(bp_valid), .bp_ready_o(bp_ready_o), .bp_addr_i(bp_addr),
        .wb_valid_o(wb_valid_o), .wb_ready_i(wb_ready), .wb_addr_o(wb_addr_o),
        .wb_data_o(wb_data_o), .wb_done_i(wb_done),
        .done_valid_o(done_valid_o), .done_src_o(done_src_o), .done_hit_o(done_hit_o),
        .ic_inval_o(ic_inval_o), .ic_addr_o(ic_addr_o)
    );

    int n_checks = 0;
    int n_err = 0;
    int tb_out = 0;

    bit               m_v   [B_LINES];
    bit               m_d   [B_LINES];
    logic [TAG_W-1:0] m_tag [B_LINES];
    logic [DW-1:0]    m_data[B_LINES];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int idx, input int off);
        return {TAG_W'(tag), IDX_W'(idx), OFF_W'(off)};
    endfunction

    function automatic logic [DW-1:0] rnd_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic string req_of(input bit src, input logic [2:0] op, input bit en);
        if (src) return "R8";
        if (op == C_SYNC) return "R9";
        if (!en) return "R10";
        case (op)
            C_INV:   return "R2";
            C_PURGE: return "R3";
            C_WBACK: return "R4";
            C_ALLOC: return "R5";
            C_ICINV: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model_step(input bit src, input logic [2:0] op_in,
                              input logic [ADDR_W-1:0] a, input logic [DW-1:0] dat,
                              output bit e_wb, output logic [ADDR_W-1:0] e_wa,
                              output logic [DW-1:0] e_wd, output bit e_hit, output bit e_ic);
        int ix;
        logic [TAG_W-1:0] tg;
        logic [2:0] op;
        bit h;
        ix = int'(a[OFF_W +: IDX_W]);
        tg = a[ADDR_W-1 -: TAG_W];
        op = src ? C_PURGE : op_in;
        e_wb = 0; e_wa = '0; e_wd = '0; e_hit = 0; e_ic = 0;
        if (op == C_SYNC || !cache_en) return;
        h = m_v[ix] && (m_tag[ix] == tg);
        case (op)
            C_INV: begin
                e_hit = h;
                if (h) begin m_v[ix] = 0; m_d[ix] = 0; end
            end
            C_PURGE: begin
                e_hit = h;
                if (h) begin
                    if (m_d[ix]) begin e_wb = 1; e_wa = {tg, IDX_W'(ix), OFF_W'(0)}; e_wd = m_data[ix]; end
                    m_v[ix] = 0; m_d[ix] = 0;
                end
            end
            C_WBACK: begin
                e_hit = h;
                if (h && m_d[ix]) begin
                    e_wb = 1; e_wa = {tg, IDX_W'(ix), OFF_W'(0)}; e_wd = m_data[ix]; m_d[ix] = 0;
                end
            end
            C_ALLOC: begin
                e_hit = h;
                if (m_v[ix] && m_d[ix] && !h) begin
                    e_wb = 1; e_wa = {m_tag[ix], IDX_W'(ix), OFF_W'(0)}; e_wd = m_data[ix];
                end
                m_v[ix] = 1; m_d[ix] = 1; m_tag[ix] = tg; m_data[ix] = dat;
            end
            C_ICINV: e_ic = 1;
            default: ;
        endcase
    endtask

    task automatic run_cmd(input bit src, input logic [2:0] op,
                           input logic [ADDR_W-1:0] a, input logic [DW-1:0] dat);
        bit e_wb, e_hit, e_ic, sync_wait, got_wb, seen, r, en_at;
        logic [ADDR_W-1:0] e_wa;
        logic [DW-1:0] e_wd;
        string req;
        int cyc;
        en_at = cache_en;
        req = req_of(src, op, en_at);
        model_step(src, op, a, dat, e_wb, e_wa, e_wd, e_hit, e_ic);
        sync_wait = !src && (op == C_SYNC) && (tb_out > 0);
        @(negedge clk);
        if (src) begin bp_valid = 1; bp_addr = a; end
        else begin lc_valid = 1; lc_op = op; lc_addr = a; lc_data = dat; end
        forever begin
            #1;
            r = src ? bp_ready_o : lc_ready_o;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        got_wb = 0; seen = 0; cyc = 0;
        while (!seen && cyc < 60) begin
            @(negedge clk);
            if (cyc == 0) begin bp_valid = 0; lc_valid = 0; end
            wb_done = 0;
            if ((sync_wait || tb_out == B_MAX) && cyc >= 4 && tb_out > 0) begin
                wb_done = 1; tb_out--;
            end
            wb_ready = ($urandom % 3) != 0;
            #1;
            if (wb_valid_o) begin
                check(tb_out + int'(wb_done) < B_MAX, "R12", "valid while tracker full", 1, 0);
                check(e_wb && !got_wb, req, "unexpected write-back", 1, DW'(e_wb));
                check(wb_addr_o == e_wa, req, "write-back address", DW'(wb_addr_o), DW'(e_wa));
                check(wb_data_o == e_wd, req, "write-back data", wb_data_o, e_wd);
                if (wb_ready) begin got_wb = 1; tb_out++; end
            end
            if (done_valid_o) begin
                seen = 1;
                check(done_src_o == src, "R13", "completion source", DW'(done_src_o), DW'(src));
                check(done_hit_o == e_hit, req, "hit flag", DW'(done_hit_o), DW'(e_hit));
                check(got_wb == e_wb, req, "write-back occurred", DW'(got_wb), DW'(e_wb));
                check(ic_inval_o == e_ic, req, "instruction invalidate strobe", DW'(ic_inval_o), DW'(e_ic));
                if (e_ic) check(ic_addr_o == a, "R6", "instruction invalidate address", DW'(ic_addr_o), DW'(a));
                if (sync_wait) begin
                    check(cyc > 5, "R9", "sync completed early at cycle", DW'(cyc), 6);
                    check(tb_out == 0, "R9", "unretired at sync completion", DW'(tb_out), 0);
                end else if (!e_wb) begin
                    check(cyc == 1, "R13", "completion cycle", DW'(cyc), 1);
                end
            end
            cyc++;
        end
        if (!seen) check(0, req, "completion timeout", DW'(cyc), 0);
        @(negedge clk);
        wb_done = 0; wb_ready = 0;
    endtask

    task automatic maybe_ack();
        if (tb_out > 0 && ($urandom % 2) == 1) begin
            @(negedge clk); wb_done = 1; tb_out--;
            @(negedge clk); wb_done = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R13", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        logic [DW-1:0] d;
        int dsrc[4];
        int nd;
        bit lc_taken;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < B_LINES; i++) begin m_v[i] = 0; m_d[i] = 0; m_tag[i] = '0; m_data[i] = '0; end

        repeat (3) @(negedge clk);
        #1;
        // R1: reset state at the ports
        check(lc_ready_o && bp_ready_o, "R1", "ready after reset", DW'({lc_ready_o, bp_ready_o}), 3);
        check(!wb_valid_o && !done_valid_o && !ic_inval_o, "R1", "quiet outputs in reset",
              DW'({wb_valid_o, done_valid_o, ic_inval_o}), 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk); #1;
        check(lc_ready_o && !wb_valid_o && !done_valid_o, "R1", "idle after reset", DW'(lc_ready_o), 1);
        run_cmd(0, C_WBACK, mk_addr(0, 0, 0), '0);

        // R11: simultaneous requests, bus first
        @(negedge clk);
        bp_valid = 1; bp_addr = mk_addr(1, 2, 4);
        lc_valid = 1; lc_op = C_INV; lc_addr = mk_addr(2, 3, 0);
        #1;
        check(bp_ready_o && !lc_ready_o, "R11", "ready pair under contention",
              DW'({bp_ready_o, lc_ready_o}), 2);
        @(negedge clk); bp_valid = 0;
        nd = 0; lc_taken = 0;
        for (int i = 0; i < 12; i++) begin
            #1;
            if (done_valid_o && nd < 4) begin dsrc[nd] = int'(done_src_o); nd++; end
            if (lc_valid && lc_ready_o) lc_taken = 1;
            @(negedge clk);
            if (lc_taken) lc_valid = 0;
        end
        check(nd == 2, "R11", "completion count", DW'(nd), 2);
        check(nd >= 1 && dsrc[0] == 1, "R11", "first completion source", DW'(dsrc[0]), 1);
        check(nd == 2 && dsrc[1] == 0, "R11", "second completion source", DW'(dsrc[1]), 0);

        // R5 / R4: allocate then clean twice
        run_cmd(0, C_ALLOC, mk_addr(1, 1, 0), rnd_line());
        run_cmd(0, C_WBACK, mk_addr(1, 1, 8), '0);
        run_cmd(0, C_WBACK, mk_addr(1, 1, 0), '0);
        // R5: clean victim replaced silently, dirty victim written back
        run_cmd(0, C_ALLOC, mk_addr(2, 1, 0), rnd_line());
        run_cmd(0, C_ALLOC, mk_addr(3, 1, 0), rnd_line());
        run_cmd(0, C_ALLOC, mk_addr(3, 1, 0), rnd_line());
        // R2: discard a dirty line, then it misses (R7)
        run_cmd(0, C_INV, mk_addr(3, 1, 0), '0);
        run_cmd(0, C_WBACK, mk_addr(3, 1, 0), '0);
        // R3: dirty purge, repeated purge misses, clean purge
        run_cmd(0, C_ALLOC, mk_addr(1, 2, 0), rnd_line());
        run_cmd(0, C_PURGE, mk_addr(1, 2, 0), '0);
        run_cmd(0, C_PURGE, mk_addr(1, 2, 0), '0);
        run_cmd(0, C_ALLOC, mk_addr(1, 3, 0), rnd_line());
        run_cmd(0, C_WBACK, mk_addr(1, 3, 0), '0);
        run_cmd(0, C_PURGE, mk_addr(1, 3, 0), '0);
        // R8: bus purge with a non-zero offset
        run_cmd(0, C_ALLOC, mk_addr(4, 4, 0), rnd_line());
        run_cmd(1, C_PURGE, mk_addr(4, 4, 12), '0);
        run_cmd(1, C_PURGE, mk_addr(4, 4, 12), '0);
        // R6: instruction invalidate leaves data line dirty
        run_cmd(0, C_ALLOC, mk_addr(5, 5, 0), rnd_line());
        run_cmd(0, C_ICINV, mk_addr(5, 5, 4), '0);
        run_cmd(0, C_PURGE, mk_addr(5, 5, 0), '0);
        // R10: disabled cache is inert, state survives
        run_cmd(0, C_ALLOC, mk_addr(6, 6, 0), rnd_line());
        cache_en = 0;
        run_cmd(0, C_PURGE, mk_addr(6, 6, 0), '0);
        run_cmd(1, C_PURGE, mk_addr(6, 6, 0), '0);
        run_cmd(0, C_ICINV, mk_addr(6, 6, 0), '0);
        run_cmd(0, C_ALLOC, mk_addr(7, 6, 0), rnd_line());
        cache_en = 1;
        run_cmd(0, C_PURGE, mk_addr(6, 6, 0), '0);
        // R9: sync waits for retirement, then sync with none pending
        if (tb_out == 0) begin
            run_cmd(0, C_ALLOC, mk_addr(2, 7, 0), rnd_line());
            run_cmd(0, C_PURGE, mk_addr(2, 7, 0), '0);
        end
        check(tb_out > 0, "R9", "pending before sync", DW'(tb_out), 1);
        run_cmd(0, C_SYNC, mk_addr(0, 0, 0), '0);
        run_cmd(0, C_SYNC, mk_addr(0, 0, 0), '0);
        // R7: reserved codes do nothing
        run_cmd(0, 3'd6, mk_addr(6, 6, 0), '0);
        run_cmd(0, 3'd7, mk_addr(6, 6, 0), '0);

        // random mix
        for (int k = 0; k < 400; k++) begin
            int r;
            logic [2:0] op;
            bit src;
            r = int'($urandom % 16);
            if (r < 5)       op = C_ALLOC;
            else if (r < 8)  op = C_PURGE;
            else if (r < 10) op = C_WBACK;
            else if (r < 12) op = C_INV;
            else if (r < 13) op = C_ICINV;
            else if (r < 14) op = C_SYNC;
            else             op = 3'(6 + ($urandom % 2));
            src = ($urandom % 6) == 0;
            cache_en = ($urandom % 20) != 0;
            d = rnd_line();
            run_cmd(src, op, mk_addr(int'($urandom % 3), int'($urandom % B_LINES),
                                     int'($urandom % LBYTES)), d);
            maybe_ack();
        end
        cache_en = 1;
        report();
    end

endmodule